// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier

This block qualifies the external active-high reset pin of an 8-bit microcontroller core whose machine cycle lasts twelve oscillator periods. The machine cycle is split into six states, S1 to S6, and each state has two phases, P1 and P2. A free-running counter inside the block produces the current state and phase. The pin is asynchronous, so it passes through a synchronizer first. The block then looks at the pin only once per machine cycle, at S5P2.

The internal reset is raised only after two samples in a row read high. A single high sample is ignored, and a pulse that misses the sample point has no effect. The reset drops at the first sample that reads low.

While the internal reset is held, the block raises a load-default strobe and supplies the values that register initialisation loads:
- every port latch gets FFh;
- the stack pointer gets 07h;
- all other special-function registers get 00h;
- the power-control register gets 00h, except bit 4, which keeps its current value;
- the serial data buffer gets its own current contents back, so it is not changed.

The interface has no data stream, so every pin is a plain level or strobe. There is no valid/ready handshake and no back-pressure.

Top module: `mcu_reset_qualifier`

## Requirements
- R1: After `por_n` is released, `mstate` and `mphase` step once per `osc_clk` cycle in this order: S1P1, S1P2, S2P1, and so on up to S6P2, and then back to S1P1. `mstate` holds the state number 1 to 6 in 3 bits. `mphase` is 0 for P1 and 1 for P2.
- R2: While `por_n` is low, `rst_int` and `ld_dflt` are 0 and the counter shows S1P1.
- R3: The pin goes through a two-flop synchronizer and is sampled only at S5P2. A high pulse whose synchronized value does not cover S5P2 has no effect.
- R4: When S5P2 samples read high on two machine cycles in a row, `rst_int` goes to 1. The new value is visible from S6P1 of the second of those cycles.
- R5: A single high sample between low samples never asserts `rst_int`.
- R6: `rst_int` returns to 0 at the first S5P2 sample that reads low, visible from S6P1 of that cycle.
- R7: `ld_dflt` is high in exactly the cycles in which `rst_int` is high.
- R8: `port_dflt` holds FFh in every port byte, `sp_dflt` is 07h and `sfr_dflt` is 00h.
- R9: `pcon_dflt` bit 4 equals `pcon_cur` bit 4. All other bits of `pcon_dflt` are 0.
- R10: `sbuf_dflt` always equals `sbuf_cur`, so reset leaves the serial buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; one period is one phase |
| por_n | input | 1 | Active-low power-on clear of the qualifier itself |
| rst_pin | input | 1 | Asynchronous external reset pin, active high |
| pcon_cur | input | 8 | Current power-control register value |
| sbuf_cur | input | 8 | Current serial buffer value |
| rst_int | output | 1 | Qualified internal reset |
| ld_dflt | output | 1 | Load-default strobe for register initialisation |
| mstate | output | 3 | Current state, 1 to 6 |
| mphase | output | 1 | Current phase, 0 = P1, 1 = P2 |
| port_dflt | output | 32 | Default values for four port latches, one byte each |
| sp_dflt | output | 8 | Stack pointer default value |
| pcon_dflt | output | 8 | Power-control default value |
| sfr_dflt | output | 8 | Default value for the remaining registers |
| sbuf_dflt | output | 8 | Serial buffer reload value |

## Verification
The assertions assume that `por_n` is applied once at power-up and that the oscillator runs without stopping after that. They also assume that `rst_pin`, however asynchronous, only reaches the sampling logic through the synchronizer. The bench changes `rst_pin` at falling clock edges early in a machine cycle, or at S4P1 for the short pulses. That leaves the synchronizer time to settle before S5P2, so every sample takes a value the bench can predict. The bench never toggles the pin near the sample point itself.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int STATES       = 6;
  localparam int PHASES       = 2;
  localparam int TICKS        = STATES * PHASES;
  localparam int IDX_W        = $clog2(TICKS);
  localparam int ST_W         = $clog2(STATES + 1);
  localparam int SAMPLE_STATE = 5;
  localparam int SAMPLE_PHASE = 1;
  localparam int SAMPLE_IDX   = (SAMPLE_STATE - 1) * PHASES + SAMPLE_PHASE;
endpackage

// File: rtl/rq_phase_gen.sv
module rq_phase_gen
  import rq_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  output logic [ST_W-1:0] state_o,
  output logic            phase_o,
  output logic            at_sample_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         idx_q <= '0;
    else if (idx_q == IDX_W'(TICKS - 1)) idx_q <= '0;
    else                                idx_q <= idx_q + IDX_W'(1);
  end

  always_comb begin
    state_o     = ST_W'(idx_q / IDX_W'(PHASES)) + ST_W'(1);
    phase_o     = 1'(idx_q % IDX_W'(PHASES));
    at_sample_o = (idx_q == IDX_W'(SAMPLE_IDX));
  end

  // R1
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idx_q == IDX_W'(TICKS - 1)) |=> (idx_q == '0));
  // R1
  step_by_one_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idx_q != IDX_W'(TICKS - 1)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/rq_sync.sv
module rq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rq_filter.sv
module rq_filter #(
  parameter int REQ_HIGH = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic at_sample_i,
  input  logic pin_s_i,
  output logic rst_o
);
  localparam int CW = $clog2(REQ_HIGH + 1);
  logic [CW-1:0] run_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q <= '0;
      rst_q <= 1'b0;
    end else if (at_sample_i) begin
      if (!pin_s_i) begin
        run_q <= '0;
        rst_q <= 1'b0;
      end else begin
        if (run_q != CW'(REQ_HIGH)) run_q <= run_q + CW'(1);
        if (run_q >= CW'(REQ_HIGH - 1)) rst_q <= 1'b1;
      end
    end
  end

  assign rst_o = rst_q;

  // R3
  change_at_sample_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_q != $past(rst_q)) |-> $past(at_sample_i));
  // R4
  rise_needs_high_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_q) |-> $past(pin_s_i));
  // R6
  low_sample_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (at_sample_i && !pin_s_i) |=> !rst_q);
  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
    run_q <= CW'(REQ_HIGH));
endmodule

// File: rtl/rq_defaults.sv
module rq_defaults #(
  parameter int NPORTS = 4
) (
  input  logic [7:0]          pcon_i,
  input  logic [7:0]          sbuf_i,
  output logic [NPORTS*8-1:0] port_o,
  output logic [7:0]          sp_o,
  output logic [7:0]          pcon_o,
  output logic [7:0]          sfr_o,
  output logic [7:0]          sbuf_o
);
  localparam logic [7:0] PORT_INIT = 8'hFF;
  localparam logic [7:0] SP_INIT   = 8'h07;
  localparam int         PCON_KEEP = 4;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign port_o[p*8 +: 8] = PORT_INIT;
    end
  endgenerate

  always_comb begin
    sp_o            = SP_INIT;
    pcon_o          = 8'h00;
    pcon_o[PCON_KEEP] = pcon_i[PCON_KEEP];
    sfr_o           = 8'h00;
    sbuf_o          = sbuf_i;
  end
endmodule

// File: rtl/mcu_reset_qualifier.sv
module mcu_reset_qualifier
  import rq_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int SYNC_STG  = 2,
  parameter int REQ_HIGH  = 2
) (
  input  logic                osc_clk,
  input  logic                por_n,
  input  logic                rst_pin,
  input  logic [7:0]          pcon_cur,
  input  logic [7:0]          sbuf_cur,
  output logic                rst_int,
  output logic                ld_dflt,
  output logic [ST_W-1:0]     mstate,
  output logic                mphase,
  output logic [NPORTS*8-1:0] port_dflt,
  output logic [7:0]          sp_dflt,
  output logic [7:0]          pcon_dflt,
  output logic [7:0]          sfr_dflt,
  output logic [7:0]          sbuf_dflt
);
  logic at_sample;
  logic pin_s;

  rq_phase_gen u_phase (
    .clk(osc_clk), .por_n(por_n),
    .state_o(mstate), .phase_o(mphase), .at_sample_o(at_sample)
  );

  rq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(osc_clk), .por_n(por_n), .d_i(rst_pin), .q_o(pin_s)
  );

  rq_filter #(.REQ_HIGH(REQ_HIGH)) u_filter (
    .clk(osc_clk), .por_n(por_n), .at_sample_i(at_sample),
    .pin_s_i(pin_s), .rst_o(rst_int)
  );

  assign ld_dflt = rst_int;

  rq_defaults #(.NPORTS(NPORTS)) u_dflt (
    .pcon_i(pcon_cur), .sbuf_i(sbuf_cur),
    .port_o(port_dflt), .sp_o(sp_dflt), .pcon_o(pcon_dflt),
    .sfr_o(sfr_dflt), .sbuf_o(sbuf_dflt)
  );

  // R1
  state_range_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mstate >= ST_W'(1)) && (mstate <= ST_W'(STATES)));
  // R3
  sample_point_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
    at_sample |-> (mstate == ST_W'(SAMPLE_STATE) && mphase == 1'b1));
endmodule

// File: tb/mcu_reset_qualifier_bench.sv
module mcu_reset_qualifier_bench;
  logic        osc_clk = 1'b0;
  logic        por_n   = 1'b0;
  logic        rst_pin = 1'b0;
  logic [7:0]  pcon_cur = 8'h00;
  logic [7:0]  sbuf_cur = 8'h00;
  logic        rst_int, ld_dflt, mphase;
  logic [2:0]  mstate;
  logic [31:0] port_dflt;
  logic [7:0]  sp_dflt, pcon_dflt, sfr_dflt, sbuf_dflt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // {mode[1:0], expected rst_int}; mode 0 = low, 1 = high, 2 = short pulse
  localparam logic [2:0] VEC [0:12] = '{
    3'b010, 3'b000, 3'b010, 3'b011, 3'b011,
    3'b100, 3'b100, 3'b100, 3'b010, 3'b100,
    3'b010, 3'b011, 3'b000
  };

  mcu_reset_qualifier u_mcu_reset_qualifier (
    .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin),
    .pcon_cur(pcon_cur), .sbuf_cur(sbuf_cur),
    .rst_int(rst_int), .ld_dflt(ld_dflt), .mstate(mstate), .mphase(mphase),
    .port_dflt(port_dflt), .sp_dflt(sp_dflt), .pcon_dflt(pcon_dflt),
    .sfr_dflt(sfr_dflt), .sbuf_dflt(sbuf_dflt)
  );

  always #10 osc_clk = ~osc_clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_at(input logic [2:0] s, input logic p);
    do @(negedge osc_clk); while (!(mstate == s && mphase == p));
  endtask

  initial begin
    repeat (3) @(negedge osc_clk);
    // R2: reset state
    check("R2", {31'd0, rst_int}, 32'd0);
    check("R2", {31'd0, ld_dflt}, 32'd0);
    check("R2", {28'd0, mstate, mphase}, {28'd0, 3'd1, 1'b0});
    por_n = 1'b1;
    // R1: full sequence S1P1..S6P2 and wrap
    for (int k = 1; k <= 13; k++) begin
      @(negedge osc_clk);
      check("R1", {28'd0, mstate, mphase},
            {28'd0, 3'(((k % 12) / 2) + 1), 1'(k % 2)});
    end
    // R3 R4 R5 R6 R7: vector walk, one machine cycle per entry
    for (int v = 0; v < 13; v++) begin
      wait_at(3'd1, 1'b0);
      rst_pin = (VEC[v][2:1] != 2'd0);
      if (VEC[v][2:1] == 2'd2) begin
        wait_at(3'd4, 1'b0);
        rst_pin = 1'b0;
      end
      wait_at(3'd6, 1'b0);
      check(VEC[v][2:1] == 2'd2 ? "R3" : (VEC[v][0] ? "R4" : "R5/R6"),
            {31'd0, rst_int}, {31'd0, VEC[v][0]});
      check("R7", {31'd0, ld_dflt}, {31'd0, VEC[v][0]});
    end
    // R6: deassertion right after assertion, checked one phase before the edge too
    rst_pin = 1'b1;
    repeat (2) begin wait_at(3'd1, 1'b0); end
    wait_at(3'd6, 1'b0);
    check("R4", {31'd0, rst_int}, 32'd1);
    wait_at(3'd1, 1'b0);
    rst_pin = 1'b0;
    wait_at(3'd5, 1'b1);
    check("R6", {31'd0, rst_int}, 32'd1);
    @(negedge osc_clk);
    check("R6", {31'd0, rst_int}, 32'd0);
    // R8 R9 R10: default values
    check("R8", port_dflt, 32'hFFFF_FFFF);
    check("R8", {24'd0, sp_dflt}, 32'h07);
    check("R8", {24'd0, sfr_dflt}, 32'h00);
    pcon_cur = 8'hFF; sbuf_cur = 8'hA5;
    #1;
    check("R9", {24'd0, pcon_dflt}, 32'h10);
    check("R10", {24'd0, sbuf_dflt}, 32'hA5);
    pcon_cur = 8'hEF; sbuf_cur = 8'h3C;
    #1;
    check("R9", {24'd0, pcon_dflt}, 32'h00);
    check("R10", {24'd0, sbuf_dflt}, 32'h3C);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule